// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a down-counter that the host arms in either a repeating or a single-shot mode. Time is measured in tick intervals taken from the system clock. Each interval lasts an integer number of clocks plus a 32-bit binary fraction of a clock. The prescaler accumulates the fraction and stretches an interval by one clock whenever the accumulator carries. This lets the average decrement rate fall between whole clock counts.

The host writes through a one-cycle register strobe: an address and a data word. The writes set the reload limit, load the count directly, set the period, start the timer and stop it. The remaining count is visible at all times on an output, and so is the current mode. A one-cycle trigger pulse marks every expiry.

When the timer is armed with an empty count, it fires at once and refills from the limit. The timer refuses to run with a zero period, or when the limit leaves nothing to count. Stopping keeps the remaining count and throws away the part of the interval that has already elapsed.

Top module: `cdt_timer`

## Requirements
- R1: After reset, mode is 0 (0 = off, 1 = repeating, 2 = single-shot), count is 0 and trigger is 0.
- R2: A run write (address 5, data bit 0 = 0) arms repeating mode. The count then drops by one at the end of every interval, and an interval lasts P clocks, where P is the integer period set at address 3. When a decrement would reach zero, trigger is high for one cycle, the count refills from the limit and the timer keeps running.
- R3: A run write with data bit 0 = 1 arms single-shot mode. At expiry, trigger pulses, the count shows 0 and mode returns to 0.
- R4: Arming with a count of 0 has two triggers: a run write, or a count write of 0 while running. Either one pulses trigger on the next cycle and loads the count from the limit. If the limit is also 0, mode goes to 0.
- R5: A run write while the integer period is 0 leaves mode at 0, and the count does not change. A run write while the timer is already running changes neither the mode nor the interval phase.
- R6: A stop write (address 6) sets mode to 0 and keeps the remaining count. This holds even when an interval ends in the same cycle. A later run starts a fresh full interval.
- R7: A count write (address 2) while running loads the value and restarts the interval from that cycle.
- R8: A limit write at address 0 leaves the count unchanged. A limit write at address 1 also loads the count and, while running, restarts the interval.
- R9: A write to the integer period (address 3) while running restarts the interval. If the written value is 0, the timer stops with the count held.
- R10: The fraction F written at address 4 is added to an accumulator at the end of every interval. Each carry out of the accumulator makes the next interval one clock longer. For example, P = 2 with F = 0x80000000 gives interval lengths 2, 2, 3, 2, 3.
- R11: A write to the integer period clears the fraction.
- R12: At a repeating expiry with a limit of 0, trigger pulses, the count stays 0 and mode goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe, one cycle |
| wrAddr | input | 3 | Register address |
| wrData | input | DATA_W | Write data |
| count | output | CNT_W | Live remaining count |
| mode | output | 2 | 0 off, 1 repeating, 2 single-shot |
| trigger | output | 1 | One-cycle expiry pulse |

## Verification
The hardest cases to reach from the ports are host writes that land on the same clock edge as an interval end. In those cases a missed priority shows up only as a count that is one too low, or one interval late. The stimulus counts clock edges from each arming write so that a stop or a period write falls exactly on an edge where an interval ends. The fractional stretch is checked by sampling the count one edge before and one edge after the decrement that the accumulated carries delay.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } mode_e;

  localparam logic [2:0] A_LIMIT    = 3'd0;
  localparam logic [2:0] A_LIMIT_RL = 3'd1;
  localparam logic [2:0] A_COUNT    = 3'd2;
  localparam logic [2:0] A_PER_INT  = 3'd3;
  localparam logic [2:0] A_PER_FRAC = 3'd4;
  localparam logic [2:0] A_RUN      = 3'd5;
  localparam logic [2:0] A_STOP     = 3'd6;

  // Strobes from control to datapath
  typedef struct packed {
    logic limitWr;
    logic cntFromData;
    logic cntFromLimit;
    logic cntDec;
    logic perIntWr;
    logic perFracWr;
    logic restart;
  } strobe_t;

endpackage

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PER_W  = 16,
  parameter int FRAC_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           st,
  input  logic              running,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cntVal,
  output logic              tickEnd,
  output logic              cntIsOne,
  output logic              cntZero,
  output logic              limitZero,
  output logic              perZero,
  output logic              dataCntZero,
  output logic              dataPerZero
);

  localparam int LEN_W = PER_W + 1;

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  limitQ;
  logic [PER_W-1:0]  perIntQ;
  logic [FRAC_W-1:0] perFracQ;
  logic [PER_W-1:0]  phaseQ;
  logic [FRAC_W-1:0] accQ;
  logic              extQ;

  logic [LEN_W-1:0]  phaseInc;
  logic [LEN_W-1:0]  curLen;

  assign phaseInc = {1'b0, phaseQ} + LEN_W'(1);
  assign curLen   = {1'b0, perIntQ} + LEN_W'(extQ);
  assign tickEnd  = running && (phaseInc == curLen);

  assign cntVal      = cntQ;
  assign cntIsOne    = (cntQ == CNT_W'(1));
  assign cntZero     = (cntQ == '0);
  assign limitZero   = (limitQ == '0);
  assign perZero     = (perIntQ == '0);
  assign dataCntZero = (wrData[CNT_W-1:0] == '0);
  assign dataPerZero = (wrData[PER_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ     <= '0;
      limitQ   <= '0;
      perIntQ  <= '0;
      perFracQ <= '0;
    end else begin
      if (st.limitWr) limitQ <= wrData[CNT_W-1:0];
      if (st.perIntWr) begin
        perIntQ  <= wrData[PER_W-1:0];
        perFracQ <= '0;
      end else if (st.perFracWr) begin
        perFracQ <= wrData[FRAC_W-1:0];
      end
      if (st.cntFromData)       cntQ <= wrData[CNT_W-1:0];
      else if (st.cntFromLimit) cntQ <= limitQ;
      else if (st.cntDec)       cntQ <= cntQ - CNT_W'(1);
    end
  end

  // Prescaler: integer phase counter plus fractional accumulator
  always_ff @(posedge clk) begin
    if (rst || st.restart) begin
      phaseQ <= '0;
      accQ   <= '0;
      extQ   <= 1'b0;
    end else if (running) begin
      if (tickEnd) begin
        phaseQ        <= '0;
        {extQ, accQ}  <= {1'b0, accQ} + {1'b0, perFracQ};
      end else begin
        phaseQ <= phaseQ + PER_W'(1);
      end
    end
  end

  // R8: the count moves only when control asks for it
  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(st.cntFromData || st.cntFromLimit || st.cntDec) |=> $stable(cntQ));

  // R11: an integer period write leaves no fraction behind
  p_frac_cleared_r11: assert property (@(posedge clk) disable iff (rst)
    st.perIntWr |=> (perFracQ == '0));

endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic       oneShotSel,
  input  logic       tickEnd,
  input  logic       cntIsOne,
  input  logic       cntZero,
  input  logic       limitZero,
  input  logic       perZero,
  input  logic       dataCntZero,
  input  logic       dataPerZero,
  output strobe_t    st,
  output logic       running,
  output mode_e      modeQ,
  output logic       trigQ
);

  mode_e modeN;
  logic  fire;
  logic  tickBlocked;

  assign running = (modeQ != MODE_OFF);

  always_comb begin
    st          = '0;
    modeN       = modeQ;
    fire        = 1'b0;
    tickBlocked = 1'b0;
    if (wrEn) begin
      case (wrAddr)
        A_LIMIT: st.limitWr = 1'b1;
        A_LIMIT_RL: begin
          tickBlocked    = 1'b1;
          st.limitWr     = 1'b1;
          st.cntFromData = 1'b1;
          if (running) begin
            st.restart = 1'b1;
            if (dataCntZero) begin
              fire  = 1'b1;
              modeN = MODE_OFF;
            end
          end
        end
        A_COUNT: begin
          tickBlocked = 1'b1;
          if (running && dataCntZero) begin
            fire            = 1'b1;
            st.restart      = 1'b1;
            st.cntFromLimit = 1'b1;
            if (limitZero) modeN = MODE_OFF;
          end else begin
            st.cntFromData = 1'b1;
            st.restart     = running;
          end
        end
        A_PER_INT: begin
          tickBlocked = 1'b1;
          st.perIntWr = 1'b1;
          if (running) begin
            if (dataPerZero) modeN = MODE_OFF;
            else             st.restart = 1'b1;
          end
        end
        A_PER_FRAC: begin
          st.perFracWr = 1'b1;
          tickBlocked  = running;
          st.restart   = running;
        end
        A_RUN: begin
          if (!running && !perZero) begin
            st.restart = 1'b1;
            modeN      = oneShotSel ? MODE_ONESHOT : MODE_PERIODIC;
            if (cntZero) begin
              fire            = 1'b1;
              st.cntFromLimit = 1'b1;
              if (limitZero) modeN = MODE_OFF;
            end
          end
        end
        A_STOP: begin
          tickBlocked = 1'b1;
          modeN       = MODE_OFF;
        end
        default: ;
      endcase
    end
    if (running && tickEnd && !tickBlocked) begin
      if (cntIsOne) begin
        fire = 1'b1;
        if (modeQ == MODE_ONESHOT) begin
          modeN     = MODE_OFF;
          st.cntDec = 1'b1;
        end else begin
          st.cntFromLimit = 1'b1;
          if (limitZero) modeN = MODE_OFF;
        end
      end else begin
        st.cntDec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MODE_OFF;
      trigQ <= 1'b0;
    end else begin
      modeQ <= modeN;
      trigQ <= fire;
    end
  end

  // R1: only the three defined mode codes appear
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (rst)
    modeQ != mode_e'(2'd3));

  // R4: a running timer never holds an empty count
  p_live_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    running |-> !cntZero);

  // R5: a run with zero period is refused
  p_run_refused_r5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == A_RUN && !running && perZero) |=> (modeQ == MODE_OFF));

  // R6: stop always ends in the off mode
  p_stop_off_r6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == A_STOP) |=> (modeQ == MODE_OFF));

  // R9: never running on a zero period
  p_no_zero_period_r9: assert property (@(posedge clk) disable iff (rst)
    running |-> !perZero);

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PER_W  = 16,
  parameter int FRAC_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [1:0]        mode,
  output logic              trigger
);

  strobe_t st;
  logic    running, tickEnd, cntIsOne, cntZero, limitZero, perZero;
  logic    dataCntZero, dataPerZero;
  mode_e   modeQ;

  cdt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .oneShotSel(wrData[0]), .tickEnd(tickEnd), .cntIsOne(cntIsOne),
    .cntZero(cntZero), .limitZero(limitZero), .perZero(perZero),
    .dataCntZero(dataCntZero), .dataPerZero(dataPerZero),
    .st(st), .running(running), .modeQ(modeQ), .trigQ(trigger)
  );

  cdt_datapath #(
    .CNT_W(CNT_W), .PER_W(PER_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .st(st), .running(running), .wrData(wrData),
    .cntVal(count), .tickEnd(tickEnd), .cntIsOne(cntIsOne),
    .cntZero(cntZero), .limitZero(limitZero), .perZero(perZero),
    .dataCntZero(dataCntZero), .dataPerZero(dataPerZero)
  );

  assign mode = modeQ;

endmodule

// File: tb/sim_cdt_timer.sv
module sim_cdt_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_LIMIT = 3'd0, A_LIMIT_RL = 3'd1, A_COUNT = 3'd2,
    A_PER_INT = 3'd3, A_PER_FRAC = 3'd4, A_RUN = 3'd5, A_STOP = 3'd6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [15:0] count;
  logic [1:0]  mode;
  logic        trigger;
  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  cdt_timer u0 (.clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .count(count), .mode(mode), .trigger(trigger));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doReset;
    rst = 1'b1; wrEn = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic tReset;
    doReset();
    chk("R1 count", 32'(count), 0);
    chk("R1 mode", 32'(mode), 0);
    chk("R1 trigger", 32'(trigger), 0);
  endtask

  task automatic tPeriodic;
    doReset();
    wr(A_LIMIT_RL, 4); wr(A_PER_INT, 3); wr(A_RUN, 0);
    chk("R2 mode", 32'(mode), 1);
    chk("R2 count armed", 32'(count), 4);
    step(3);  chk("R2 first tick", 32'(count), 3);
    step(9);  chk("R2 reload", 32'(count), 4);
    chk("R2 trigger", 32'(trigger), 1);
    chk("R2 still running", 32'(mode), 1);
    step(1);  chk("R2 trigger one cycle", 32'(trigger), 0);
    step(2);  chk("R2 next period", 32'(count), 3);
  endtask

  task automatic tOneshot;
    doReset();
    wr(A_LIMIT_RL, 2); wr(A_PER_INT, 1); wr(A_RUN, 1);
    chk("R3 mode", 32'(mode), 2);
    step(1); chk("R3 count", 32'(count), 1);
    step(1); chk("R3 count zero", 32'(count), 0);
    chk("R3 off", 32'(mode), 0);
    chk("R3 trigger", 32'(trigger), 1);
    step(3); chk("R3 stays zero", 32'(count), 0);
    chk("R3 no retrigger", 32'(trigger), 0);
  endtask

  task automatic tArmZero;
    doReset();
    wr(A_LIMIT, 5); wr(A_PER_INT, 4); wr(A_RUN, 0);
    chk("R4 trigger", 32'(trigger), 1);
    chk("R4 count from limit", 32'(count), 5);
    chk("R4 mode", 32'(mode), 1);
    doReset();
    wr(A_PER_INT, 4); wr(A_RUN, 0);
    chk("R4 zero limit trigger", 32'(trigger), 1);
    chk("R4 zero limit off", 32'(mode), 0);
    doReset();
    wr(A_LIMIT, 6); wr(A_COUNT, 3); wr(A_PER_INT, 2); wr(A_RUN, 0);
    step(1);
    wr(A_COUNT, 0);
    chk("R4 count write zero trigger", 32'(trigger), 1);
    chk("R4 count write zero reload", 32'(count), 6);
  endtask

  task automatic tRunRefuse;
    doReset();
    wr(A_COUNT, 3); wr(A_RUN, 0);
    chk("R5 refused", 32'(mode), 0);
    chk("R5 no trigger", 32'(trigger), 0);
    step(4); chk("R5 count held", 32'(count), 3);
    wr(A_PER_INT, 5); wr(A_RUN, 0);
    step(1);
    wr(A_RUN, 1);
    chk("R5 run ignored mode", 32'(mode), 1);
    step(2); chk("R5 no restart before", 32'(count), 3);
    step(1); chk("R5 no restart tick", 32'(count), 2);
  endtask

  task automatic tStop;
    doReset();
    wr(A_COUNT, 10); wr(A_PER_INT, 3); wr(A_RUN, 0);
    step(5); chk("R6 before stop", 32'(count), 9);
    wr(A_STOP, 0);
    chk("R6 stop beats tick", 32'(count), 9);
    chk("R6 off", 32'(mode), 0);
    step(5); chk("R6 frozen", 32'(count), 9);
    wr(A_RUN, 0);
    step(2); chk("R6 fresh interval", 32'(count), 9);
    step(1); chk("R6 fresh tick", 32'(count), 8);
  endtask

  task automatic tCountWr;
    doReset();
    wr(A_LIMIT_RL, 20); wr(A_PER_INT, 4); wr(A_RUN, 0);
    step(2);
    wr(A_COUNT, 7);
    chk("R7 loaded", 32'(count), 7);
    step(3); chk("R7 restart hold", 32'(count), 7);
    step(1); chk("R7 restart tick", 32'(count), 6);
  endtask

  task automatic tLimit;
    doReset();
    wr(A_PER_INT, 3); wr(A_LIMIT_RL, 9);
    chk("R8 reload load", 32'(count), 9);
    wr(A_LIMIT, 3);
    chk("R8 plain no load", 32'(count), 9);
    wr(A_RUN, 0);
    step(1);
    wr(A_LIMIT_RL, 5);
    step(1); chk("R8 reload restart", 32'(count), 5);
    step(2); chk("R8 reload tick", 32'(count), 4);
  endtask

  task automatic tPeriod;
    doReset();
    wr(A_LIMIT_RL, 10); wr(A_PER_INT, 3); wr(A_RUN, 0);
    step(2);
    wr(A_PER_INT, 3);
    chk("R9 restart no tick", 32'(count), 10);
    step(2); chk("R9 restart hold", 32'(count), 10);
    step(1); chk("R9 restart tick", 32'(count), 9);
    wr(A_PER_INT, 0);
    chk("R9 zero period off", 32'(mode), 0);
    step(3); chk("R9 count held", 32'(count), 9);
  endtask

  task automatic tFrac;
    doReset();
    wr(A_LIMIT_RL, 10); wr(A_PER_INT, 2); wr(A_PER_FRAC, 32'h8000_0000);
    wr(A_RUN, 0);
    step(11); chk("R10 stretched", 32'(count), 6);
    step(1);  chk("R10 fifth tick", 32'(count), 5);
  endtask

  task automatic tFracClear;
    doReset();
    wr(A_LIMIT_RL, 10); wr(A_PER_INT, 2); wr(A_PER_FRAC, 32'h8000_0000);
    wr(A_PER_INT, 2); wr(A_RUN, 0);
    step(12); chk("R11 fraction cleared", 32'(count), 4);
  endtask

  task automatic tLimitZero;
    doReset();
    wr(A_LIMIT_RL, 2); wr(A_PER_INT, 1); wr(A_RUN, 0);
    wr(A_LIMIT, 0);
    chk("R12 tick with limit write", 32'(count), 1);
    step(1);
    chk("R12 trigger", 32'(trigger), 1);
    chk("R12 count", 32'(count), 0);
    chk("R12 off", 32'(mode), 0);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tPeriodic();
    tOneshot();
    tArmZero();
    tRunRefuse();
    tStop();
    tCountWr();
    tLimit();
    tPeriod();
    tFrac();
    tFracClear();
    tLimitZero();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule